// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block works out where instruction fetch goes next in a RISC core that has one architectural delay slot. Each cycle in which an instruction retires, the core presents that instruction's PC, a 3-bit control-transfer code, a signed word offset, a register operand, the compare flag, and the saved exception PC and status word. The unit always reports the sequential successor PC. For a transfer that is taken, it records the destination. It then lets exactly one more instruction retire, which is the delay slot. After that it issues a one-cycle redirect carrying the recorded destination.

There are eight transfer kinds. Two are conditional branches: one taken when the flag is set and one taken when the flag is clear. Two are PC-relative jumps, one plain and one that writes a link. Two are register-indirect jumps, again one plain and one that writes a link. One is return from exception, and the last is the code for no transfer. Linking jumps write PC+8 into register 9 through the shared register-file write port, so a return skips the delay-slot instruction. Return from exception has no delay slot. It asks for the status register to be restored, and on the next cycle it redirects to the saved exception PC. Retire cycles may be separated by idle cycles. While the unit waits for the delay slot, that pending state is held.

Top module: `nxpc_unit`

## Requirements
- R1: After synchronous reset, `redir_o` and `in_slot_o` are both 0.
- R2: `seq_pc_o` always equals `pc_i + 4`, combinationally.
- R3: A branch coded 1 is taken only when `flag_i` is 1, and a branch coded 2 is taken only when `flag_i` is 0. A branch that is not taken raises neither `in_slot_o` nor `redir_o`.
- R4: For codes 1 to 4 the destination is `pc_i` plus the sign-extended `ofs_i` multiplied by 4, with wraparound modulo 2^32.
- R5: For codes 5 and 6 the destination is `rtgt_i` used unchanged, with no scaling and no alignment.
- R6: A taken transfer with codes 1 to 6 sets `in_slot_o` from the next cycle. `in_slot_o` holds through cycles where `valid_i` is 0, until the next retire. In the cycle after that retire, `redir_o` pulses for one cycle with `redir_pc_o` set to the recorded destination, and `in_slot_o` returns to 0.
- R7: When code 4 or 6 retires outside a delay slot, `link_we_o` is 1 in that same cycle, with `link_idx_o` = 9 and `link_data_o` = `pc_i + 8`. In every other cycle `link_we_o` is 0.
- R8: When code 7 retires outside a delay slot, `sr_we_o` = 1 and `sr_val_o` = `esr_i` in that cycle. In the next cycle `redir_o` = 1 with `redir_pc_o` equal to the `epc_i` sampled at retire, and `in_slot_o` stays 0.
- R9: A transfer code retiring in a delay slot has no effect. It writes no link and restores no status, and the redirect that follows carries the earlier destination.
- R10: With `valid_i` = 0, any code has no effect: no link write, no status write, and no change to `in_slot_o` or `redir_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction retires this cycle |
| pc_i | input | 32 | PC of the retiring instruction |
| op_i | input | 3 | Transfer code: 0 none, 1 branch if flag, 2 branch if not flag, 3 relative jump, 4 relative jump and link, 5 register jump, 6 register jump and link, 7 return from exception |
| ofs_i | input | 26 | Signed word offset |
| rtgt_i | input | 32 | Register operand used as the target |
| flag_i | input | 1 | Compare flag |
| epc_i | input | 32 | Saved exception PC |
| esr_i | input | 32 | Saved status word |
| seq_pc_o | output | 32 | Sequential next PC |
| redir_o | output | 1 | One-cycle fetch redirect strobe |
| redir_pc_o | output | 32 | Redirect destination |
| in_slot_o | output | 1 | The next retiring instruction is a delay slot |
| link_we_o | output | 1 | Link-register write enable |
| link_idx_o | output | 5 | Link-register index |
| link_data_o | output | 32 | Link value |
| sr_we_o | output | 1 | Status restore enable |
| sr_val_o | output | 32 | Status value to restore |

## Verification
The slot flag and the held destination are the only internal state. An error in either shows up within at most two retires. A slot flag left stuck high swallows the next transfer, so there is no link write and no redirect where one is due. A slot flag that fails to set produces no redirect after the delay slot. A corrupted held destination shows up on `redir_pc_o` in the very cycle the redirect fires. The bench checks every taken and not-taken transfer through to its redirect cycle. It also inserts idle gaps inside the delay slot and places transfers inside slots.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    localparam int XFER_W = 3;

    typedef enum logic [XFER_W-1:0] {
        XFER_NONE      = 3'd0,
        XFER_BR_SET    = 3'd1,
        XFER_BR_CLR    = 3'd2,
        XFER_JREL      = 3'd3,
        XFER_JREL_LINK = 3'd4,
        XFER_JREG      = 3'd5,
        XFER_JREG_LINK = 3'd6,
        XFER_EXC_RET   = 3'd7
    } xfer_e;

    typedef enum logic [1:0] {
        SRC_REL = 2'd0,
        SRC_REG = 2'd1,
        SRC_EXC = 2'd2
    } tgt_src_e;

    typedef struct packed {
        logic     taken;    // a delayed transfer is taken
        logic     link;     // write PC+8 to the link register
        logic     restore;  // exception return: restore status, redirect now
        tgt_src_e src;
    } xfer_ctl_t;

    localparam xfer_ctl_t CTL_IDLE = '{taken: 1'b0, link: 1'b0, restore: 1'b0, src: SRC_REL};

    function automatic xfer_ctl_t classify(input xfer_e op, input logic flag);
        xfer_ctl_t c;
        c = CTL_IDLE;
        unique case (op)
            XFER_BR_SET:    c.taken = flag;
            XFER_BR_CLR:    c.taken = ~flag;
            XFER_JREL:      c.taken = 1'b1;
            XFER_JREL_LINK: begin c.taken = 1'b1; c.link = 1'b1; end
            XFER_JREG:      begin c.taken = 1'b1; c.src = SRC_REG; end
            XFER_JREG_LINK: begin c.taken = 1'b1; c.link = 1'b1; c.src = SRC_REG; end
            XFER_EXC_RET:   begin c.restore = 1'b1; c.src = SRC_EXC; end
            default:        c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic              valid_i,
    input  logic              in_slot_i,
    input  xfer_e             op_i,
    input  logic              flag_i,
    output xfer_ctl_t         ctl_o
);
    // A transfer retiring inside a delay slot, or no retire at all, is inert.
    always_comb begin
        if (valid_i && !in_slot_i) ctl_o = classify(op_i, flag_i);
        else                       ctl_o = CTL_IDLE;
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 26
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] ofs_i,
    input  logic [AW-1:0] rtgt_i,
    input  logic [AW-1:0] epc_i,
    input  tgt_src_e      src_i,
    output logic [AW-1:0] tgt_o
);
    localparam int SHIFT = 2;

    logic [AW-1:0] ofs_bytes;
    logic [AW-1:0] rel_tgt;

    generate
        if (AW >= OW + SHIFT) begin : g_sext
            assign ofs_bytes = {{(AW-OW-SHIFT){ofs_i[OW-1]}}, ofs_i, {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [OW+SHIFT-1:0] wide;
            assign wide      = {ofs_i, {SHIFT{1'b0}}};
            assign ofs_bytes = wide[AW-1:0];
        end
    endgenerate

    assign rel_tgt = pc_i + ofs_bytes;

    always_comb begin
        unique case (src_i)
            SRC_REG: tgt_o = rtgt_i;
            SRC_EXC: tgt_o = epc_i;
            default: tgt_o = rel_tgt;
        endcase
    end
endmodule

// File: rtl/nxpc_link.sv
module nxpc_link #(
    parameter int AW       = 32,
    parameter int IW       = 5,
    parameter int LINK_REG = 9
) (
    input  logic          link_i,
    input  logic [AW-1:0] pc_i,
    output logic          we_o,
    output logic [IW-1:0] idx_o,
    output logic [AW-1:0] data_o
);
    localparam logic [AW-1:0] SKIP = AW'(8);

    assign we_o   = link_i;
    assign idx_o  = IW'(LINK_REG);
    assign data_o = pc_i + SKIP;
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OW       = 26,
    parameter int SW       = 32,
    parameter int IW       = 5,
    parameter int LINK_REG = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [AW-1:0] pc_i,
    input  logic [2:0]    op_i,
    input  logic [OW-1:0] ofs_i,
    input  logic [AW-1:0] rtgt_i,
    input  logic          flag_i,
    input  logic [AW-1:0] epc_i,
    input  logic [SW-1:0] esr_i,
    output logic [AW-1:0] seq_pc_o,
    output logic          redir_o,
    output logic [AW-1:0] redir_pc_o,
    output logic          in_slot_o,
    output logic          link_we_o,
    output logic [IW-1:0] link_idx_o,
    output logic [AW-1:0] link_data_o,
    output logic          sr_we_o,
    output logic [SW-1:0] sr_val_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    xfer_ctl_t     ctl;
    logic [AW-1:0] tgt;
    logic          slot_q;
    logic [AW-1:0] held_q;
    logic          redir_q;
    logic [AW-1:0] redir_pc_q;

    nxpc_decode u_dec (
        .valid_i   (valid_i),
        .in_slot_i (slot_q),
        .op_i      (xfer_e'(op_i)),
        .flag_i    (flag_i),
        .ctl_o     (ctl)
    );

    nxpc_target #(.AW(AW), .OW(OW)) u_tgt (
        .pc_i   (pc_i),
        .ofs_i  (ofs_i),
        .rtgt_i (rtgt_i),
        .epc_i  (epc_i),
        .src_i  (ctl.src),
        .tgt_o  (tgt)
    );

    nxpc_link #(.AW(AW), .IW(IW), .LINK_REG(LINK_REG)) u_lnk (
        .link_i (ctl.link),
        .pc_i   (pc_i),
        .we_o   (link_we_o),
        .idx_o  (link_idx_o),
        .data_o (link_data_o)
    );

    // Delay-slot tracking: a taken transfer arms the slot; the next retire
    // consumes it and releases the held destination one cycle later.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= 1'b0;
            held_q     <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            redir_q <= 1'b0;
            if (valid_i && slot_q) begin
                slot_q     <= 1'b0;
                redir_q    <= 1'b1;
                redir_pc_q <= held_q;
            end else if (ctl.taken) begin
                slot_q <= 1'b1;
                held_q <= tgt;
            end else if (ctl.restore) begin
                redir_q    <= 1'b1;
                redir_pc_q <= tgt;
            end
        end
    end

    assign seq_pc_o   = pc_i + STEP;
    assign redir_o    = redir_q;
    assign redir_pc_o = redir_pc_q;
    assign in_slot_o  = slot_q;
    assign sr_we_o    = ctl.restore;
    assign sr_val_o   = esr_i;

    // ---------------- assertions ----------------
    p_slot_release_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && in_slot_o) |=> (redir_o && !in_slot_o));

    p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && in_slot_o) |=> (in_slot_o && $stable(in_slot_o)));

    p_link_value_r7: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (valid_i && link_data_o == pc_i + AW'(8)));

    p_no_link_in_slot_r9: assert property (@(posedge clk) disable iff (rst)
        in_slot_o |-> (!link_we_o && !sr_we_o));

    p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !in_slot_o && op_i == 3'd1 && !flag_i) |=> !in_slot_o);

    p_exc_return_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !in_slot_o && op_i == 3'd7)
            |=> (redir_o && !in_slot_o && redir_pc_o == $past(epc_i)));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !in_slot_o) |=> !in_slot_o);
endmodule

// File: tb/sim_nxpc_unit.sv
module sim_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] pc_i;
    logic [2:0]  op_i;
    logic [25:0] ofs_i;
    logic [31:0] rtgt_i;
    logic        flag_i;
    logic [31:0] epc_i;
    logic [31:0] esr_i;
    logic [31:0] seq_pc_o;
    logic        redir_o;
    logic [31:0] redir_pc_o;
    logic        in_slot_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;
    logic        sr_we_o;
    logic [31:0] sr_val_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nxpc_unit u0 (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] pc;
        logic [25:0] ofs;
        logic [31:0] rtgt;
        logic        flag;
        logic        taken;
        logic        link;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'h1000, 26'd5,        32'h0,         1'b1, 1'b1, 1'b0, 32'h1014},     // R3 R4
        '{3'd1, 32'h1000, 26'd5,        32'h0,         1'b0, 1'b0, 1'b0, 32'h0},        // R3
        '{3'd2, 32'h2000, 26'h3FFFFFD,  32'h0,         1'b0, 1'b1, 1'b0, 32'h1FF4},     // R3 R4
        '{3'd2, 32'h2000, 26'h3FFFFFD,  32'h0,         1'b1, 1'b0, 1'b0, 32'h0},        // R3
        '{3'd3, 32'h3000, 26'h100,      32'h0,         1'b0, 1'b1, 1'b0, 32'h3400},     // R4
        '{3'd3, 32'h3000, 26'h3FFFC00,  32'h0,         1'b1, 1'b1, 1'b0, 32'h2000},     // R4
        '{3'd4, 32'h4000, 26'd16,       32'h0,         1'b0, 1'b1, 1'b1, 32'h4040},     // R4 R7
        '{3'd5, 32'h5000, 26'd7,        32'h00012345,  1'b0, 1'b1, 1'b0, 32'h00012345}, // R5
        '{3'd6, 32'h6000, 26'd7,        32'h80000010,  1'b1, 1'b1, 1'b1, 32'h80000010}  // R5 R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] pc,
                         input logic [25:0] ofs, input logic [31:0] rt, input logic fl);
        valid_i = v; op_i = op; pc_i = pc; ofs_i = ofs; rtgt_i = rt; flag_i = fl;
        #0.5;
    endtask

    initial begin
        #150000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; epc_i = 32'h0; esr_i = 32'h0;
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        tick(); tick();
        rst = 1'b0;
        chk("R1 redir", {31'd0, redir_o}, 32'd0);
        chk("R1 slot", {31'd0, in_slot_o}, 32'd0);

        // Table walk: transfer, then a plain delay-slot/successor instruction
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].pc, VECS[i].ofs, VECS[i].rtgt, VECS[i].flag);
            chk("R2 seq pc", seq_pc_o, VECS[i].pc + 32'd4);
            chk("R7 link we", {31'd0, link_we_o}, {31'd0, VECS[i].link});
            if (VECS[i].link) begin
                chk("R7 link idx", {27'd0, link_idx_o}, 32'd9);
                chk("R7 link data", link_data_o, VECS[i].pc + 32'd8);
            end
            tick();
            chk("R6 R3 slot set", {31'd0, in_slot_o}, {31'd0, VECS[i].taken});
            chk("R3 no early redir", {31'd0, redir_o}, 32'd0);
            drive(1'b1, 3'd0, VECS[i].pc + 32'd4, 26'd0, 32'h0, 1'b0);
            tick();
            chk("R6 R3 redirect", {31'd0, redir_o}, {31'd0, VECS[i].taken});
            chk("R6 slot clear", {31'd0, in_slot_o}, 32'd0);
            if (VECS[i].taken) chk("R4 R5 target", redir_pc_o, VECS[i].tgt);
            drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
            tick();
            chk("R6 pulse single", {31'd0, redir_o}, 32'd0);
        end

        // R8: exception return
        epc_i = 32'h9000; esr_i = 32'h55;
        drive(1'b1, 3'd7, 32'h7000, 26'd0, 32'h0, 1'b0);
        chk("R8 sr we", {31'd0, sr_we_o}, 32'd1);
        chk("R8 sr val", sr_val_o, 32'h55);
        chk("R8 no link", {31'd0, link_we_o}, 32'd0);
        tick();
        epc_i = 32'h0;
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        chk("R8 redirect", {31'd0, redir_o}, 32'd1);
        chk("R8 target", redir_pc_o, 32'h9000);
        chk("R8 no slot", {31'd0, in_slot_o}, 32'd0);
        chk("R8 sr we low after", {31'd0, sr_we_o}, 32'd0);
        tick();

        // R6: idle gaps inside the delay slot
        drive(1'b1, 3'd3, 32'h100, 26'd4, 32'h0, 1'b0);
        tick();
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 slot held", {31'd0, in_slot_o}, 32'd1);
            chk("R6 no redir during gap", {31'd0, redir_o}, 32'd0);
        end
        // R9: linking jump inside the slot is ignored
        drive(1'b1, 3'd4, 32'h104, 26'd64, 32'h0, 1'b0);
        chk("R9 no link in slot", {31'd0, link_we_o}, 32'd0);
        tick();
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        chk("R9 redir first target", redir_pc_o, 32'h110);
        chk("R9 redir", {31'd0, redir_o}, 32'd1);
        chk("R9 slot not rearmed", {31'd0, in_slot_o}, 32'd0);
        tick();

        // R9: exception return inside the slot is ignored
        drive(1'b1, 3'd5, 32'h200, 26'd0, 32'h00000AA0, 1'b0);
        tick();
        epc_i = 32'hDEAD0000; esr_i = 32'h77;
        drive(1'b1, 3'd7, 32'h204, 26'd0, 32'h0, 1'b0);
        chk("R9 no sr restore in slot", {31'd0, sr_we_o}, 32'd0);
        tick();
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        chk("R9 redir keeps reg target", redir_pc_o, 32'h00000AA0);
        tick();
        chk("R9 no second redir", {31'd0, redir_o}, 32'd0);

        // R10: codes ignored without valid
        drive(1'b0, 3'd4, 32'h300, 26'd8, 32'h0, 1'b1);
        chk("R10 no link", {31'd0, link_we_o}, 32'd0);
        tick();
        drive(1'b0, 3'd7, 32'h300, 26'd8, 32'h0, 1'b1);
        chk("R10 no sr", {31'd0, sr_we_o}, 32'd0);
        chk("R10 no slot", {31'd0, in_slot_o}, 32'd0);
        tick();
        chk("R10 no redir", {31'd0, redir_o}, 32'd0);

        // R1: reset in the middle of a pending slot
        drive(1'b1, 3'd3, 32'h400, 26'd1, 32'h0, 1'b0);
        tick();
        drive(1'b0, 3'd0, 32'h0, 26'd0, 32'h0, 1'b0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 slot cleared", {31'd0, in_slot_o}, 32'd0);
        chk("R1 redir cleared", {31'd0, redir_o}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule